// File: doc/BRIEF.md
# Display Memory Controller with Host Command Port

This block holds sixteen display bytes in a small register memory and connects them to two sides. A host writes command bytes and data bytes. The commands place separate read and write pointers. Each pointer can step forward by itself after every access. Other commands protect either half of a byte from writes, blank either half of the display output, clear the whole memory to one of three fill values, and choose the display size and entry direction.

On the display side, a refresh position advances on each `scanTick` pulse. It wraps after the last active digit. The block presents the byte at that position, with the blanking applied, on `segOut`.

Two entry directions are supported. In left-entry mode each data byte lands at the write pointer. In right-entry mode each data byte enters at the last active digit and the existing digits move one place toward position 0, the way a calculator display fills.

Top module: `disp_ram_ctrl`

## Requirements
- R1: After reset the memory holds 0x00 in every location and both pointers are at 0 with stepping off. The mode is 8 digits with left entry. `rdData`, `rdValid`, `busy`, `scanPos` and `segOut` are all 0.
- R2: Command byte 100SAAAA (bits 7:5 = 100) loads the write pointer with AAAA and its step flag with S. In left-entry mode, each accepted data write stores `wrData` at the write pointer. When S=1 the pointer then advances by one and wraps from 15 to 0.
- R3: Command byte 011SAAAA loads the read pointer and its step flag. On `rdReq`, the addressed byte appears on `rdData` one clock later, with `rdValid` high for that one cycle. When S=1 the pointer advances by one after each read.
- R4: Command byte 1010KLBC sets the write masks. K=1 (bit 3) keeps the upper nibble of the destination byte unchanged on data writes. L=1 (bit 2) does the same for the lower nibble.
- R5: In the same command, B=1 (bit 1) forces `segOut[7:4]` to 0 and C=1 (bit 0) forces `segOut[3:0]` to 0. The stored bytes are not altered.
- R6: Command byte 1100FFxx clears the memory, one location per clock from address 0 upward. The fill value is 0x00 for FF = 00 or 01, 0x20 for FF = 10 and 0xFF for FF = 11. `busy` is high for exactly 16 cycles, starting the cycle after the command. The write pointer is set to 0 and its step flag is kept.
- R7: While `busy` is high, command bytes and data writes are ignored.
- R8: Command byte 000WExxx sets the mode. W (bit 4) = 1 selects 16 digits and W = 0 selects 8. E (bit 3) = 1 selects right entry. Each `scanTick` advances `scanPos`, which wraps to 0 after position 7 in 8-digit mode and after position 15 in 16-digit mode. `segOut` shows the byte at `scanPos`.
- R9: In right-entry mode a data write ignores the write pointer. Every active position below the last one takes the byte of the position above it, and the new byte goes to the last active position (7 or 15). Locations beyond the active digits are untouched. A masked nibble of the new byte keeps the value the last position held before the shift.
- R10: A data write presented in the same cycle as a command byte is ignored.
- R11: Command bytes with bits 7:5 = 001, 010 or 111, or bits 7:4 = 1011 or 1101, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command byte |
| wrValid | input | 1 | Data write strobe |
| wrData | input | 8 | Data byte to store |
| rdReq | input | 1 | Data read request |
| rdData | output | 8 | Byte read, valid one clock after the request |
| rdValid | output | 1 | High in the cycle `rdData` carries a new read |
| busy | output | 1 | Clear sequence in progress |
| scanTick | input | 1 | Advance the refresh position |
| scanPos | output | 4 | Current refresh position |
| segOut | output | 8 | Byte at the refresh position, with blanking applied |

## Verification
The hardest case to reach is a command or a data write that arrives while a clear is running. Those inputs must leave no trace, yet they can only be seen later, through reads.

The bench waits on the `busy` level edge by edge and injects a write-pointer command and a data byte at known cycles inside the 16-cycle clear window. It then shows that the write pointer came back at 0 and that the injected location still holds the fill value.

The right-entry shift at both digit counts is reached by first filling known bytes with left entry. The mode is then switched, and every shifted location is read back, including a location beyond the active digits.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANES  = DATA_W / 4;

  typedef struct packed {
    logic              memWr;
    logic              memShift;
    logic [ADDR_W-1:0] wrAddr;
    logic [LANES-1:0]  keep;
    logic              fillWr;
    logic [ADDR_W-1:0] fillAddr;
    logic [DATA_W-1:0] fillVal;
    logic              memRd;
    logic [ADDR_W-1:0] rdAddr;
    logic              wide;
    logic [LANES-1:0]  blank;
  } dispStrobe_t;

  function automatic logic [DATA_W-1:0] fillPattern(input logic [1:0] sel);
    case (sel)
      2'b10:   fillPattern = DATA_W'(8'h20);
      2'b11:   fillPattern = '1;
      default: fillPattern = '0;
    endcase
  endfunction
endpackage

// File: rtl/disp_ctrl.sv
module disp_ctrl
  import disp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdByte,
  input  logic              wrValid,
  input  logic              rdReq,
  output dispStrobe_t       str,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] wrPtr, rdPtr, clrCnt;
  logic              wrStep, rdStep, wide, rightEntry;
  logic [LANES-1:0]  keep, blank;
  logic [DATA_W-1:0] clrVal;

  logic cmdTake, isMode, isRdAddr, isWrAddr, isMask, isClear, dataWr;

  always_comb begin
    cmdTake  = cmdValid && !busy;
    isMode   = cmdByte[7:5] == 3'b000;
    isRdAddr = cmdByte[7:5] == 3'b011;
    isWrAddr = cmdByte[7:5] == 3'b100;
    isMask   = cmdByte[7:4] == 4'b1010;
    isClear  = cmdByte[7:4] == 4'b1100;
    dataWr   = wrValid && !cmdValid && !busy;
  end

  always_comb begin
    str.memWr    = dataWr && !rightEntry;
    str.memShift = dataWr && rightEntry;
    str.wrAddr   = wrPtr;
    str.keep     = keep;
    str.fillWr   = busy;
    str.fillAddr = clrCnt;
    str.fillVal  = clrVal;
    str.memRd    = rdReq;
    str.rdAddr   = rdPtr;
    str.wide     = wide;
    str.blank    = blank;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wide       <= 1'b0;
      rightEntry <= 1'b0;
      keep       <= '0;
      blank      <= '0;
    end else if (cmdTake) begin
      if (isMode) begin
        wide       <= cmdByte[4];
        rightEntry <= cmdByte[3];
      end
      if (isMask) begin
        keep  <= cmdByte[3:2];
        blank <= cmdByte[1:0];
      end
    end
  end

  // write pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      wrStep <= 1'b0;
    end else if (cmdTake && isWrAddr) begin
      wrPtr  <= cmdByte[ADDR_W-1:0];
      wrStep <= cmdByte[4];
    end else if (cmdTake && isClear) begin
      wrPtr <= '0;
    end else if (str.memWr && wrStep) begin
      wrPtr <= wrPtr + 1'b1;
    end
  end

  // read pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      rdStep <= 1'b0;
    end else if (cmdTake && isRdAddr) begin
      rdPtr  <= cmdByte[ADDR_W-1:0];
      rdStep <= cmdByte[4];
    end else if (rdReq && rdStep) begin
      rdPtr <= rdPtr + 1'b1;
    end
  end

  // clear sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      clrCnt <= '0;
      clrVal <= '0;
    end else if (cmdTake && isClear) begin
      busy   <= 1'b1;
      clrCnt <= '0;
      clrVal <= fillPattern(cmdByte[3:2]);
    end else if (busy) begin
      clrCnt <= clrCnt + 1'b1;
      if (clrCnt == LAST_ADDR) busy <= 1'b0;
    end
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && clrCnt != LAST_ADDR |=> busy);

  // R7
  busy_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(wrPtr));

  // R3
  rd_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && rdStep && !(cmdTake && isRdAddr) |=> rdPtr == $past(rdPtr) + 1'b1);
endmodule

// File: rtl/disp_datapath.sv
module disp_datapath
  import disp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dispStrobe_t       str,
  input  logic [DATA_W-1:0] wrData,
  input  logic              scanTick,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] scanPos,
  output logic [DATA_W-1:0] segOut
);
  localparam int HALF = DEPTH / 2;
  localparam logic [ADDR_W-1:0] LAST_WIDE   = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] LAST_NARROW = ADDR_W'(HALF - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] lastPos;
  logic [DATA_W-1:0] baseByte, merged, shown;

  always_comb begin
    lastPos  = str.wide ? LAST_WIDE : LAST_NARROW;
    baseByte = str.memShift ? mem[lastPos] : mem[str.wrAddr];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*4 +: 4] = str.keep[g] ? baseByte[g*4 +: 4] : wrData[g*4 +: 4];
    assign segOut[g*4 +: 4] = str.blank[g] ? 4'h0 : shown[g*4 +: 4];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (str.fillWr) begin
      mem[str.fillAddr] <= str.fillVal;
    end else if (str.memWr) begin
      mem[str.wrAddr] <= merged;
    end else if (str.memShift) begin
      for (int i = 0; i < DEPTH - 1; i++)
        if (ADDR_W'(i) < lastPos) mem[i] <= mem[i+1];
      mem[lastPos] <= merged;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= str.memRd;
      if (str.memRd) rdData <= mem[str.rdAddr];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         scanPos <= '0;
    else if (scanTick) scanPos <= (scanPos >= lastPos) ? '0 : scanPos + 1'b1;
  end

  assign shown = mem[scanPos];

  logic [3:0] destUpper;
  assign destUpper = mem[str.wrAddr][DATA_W-1 -: 4];

  // R7
  fill_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.fillWr |-> !str.memWr && !str.memShift);

  // R6
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.fillWr |=> mem[$past(str.fillAddr)] == $past(str.fillVal));

  // R4
  keep_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.memWr && str.keep[LANES-1] |=> mem[$past(str.wrAddr)][DATA_W-1 -: 4] == $past(destUpper));

  // R8
  scan_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanTick && scanPos == lastPos |=> scanPos == '0);

  // R3
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.memRd |=> rdValid);
endmodule

// File: rtl/disp_ram_ctrl.sv
module disp_ram_ctrl
  import disp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdByte,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdReq,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              busy,
  input  logic              scanTick,
  output logic [ADDR_W-1:0] scanPos,
  output logic [DATA_W-1:0] segOut
);
  dispStrobe_t str;

  disp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .wrValid(wrValid), .rdReq(rdReq), .str(str), .busy(busy)
  );

  disp_datapath u_dp (
    .clk(clk), .rstN(rstN), .str(str), .wrData(wrData), .scanTick(scanTick),
    .rdData(rdData), .rdValid(rdValid), .scanPos(scanPos), .segOut(segOut)
  );
endmodule

// File: tb/disp_ram_ctrl_tb.sv
module disp_ram_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0, wrValid = 1'b0, rdReq = 1'b0, scanTick = 1'b0;
  logic [7:0] cmdByte = '0, wrData = '0;
  logic [7:0] rdData, segOut;
  logic       rdValid, busy;
  logic [3:0] scanPos;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  disp_ram_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .wrValid(wrValid), .wrData(wrData), .rdReq(rdReq), .rdData(rdData),
    .rdValid(rdValid), .busy(busy), .scanTick(scanTick), .scanPos(scanPos),
    .segOut(segOut)
  );

  // {op, data, expected}: op 0 = command, 1 = data write, 2 = read and compare
  localparam int NV = 37;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h90, 8'h00}, {2'd1, 8'h11, 8'h00}, {2'd1, 8'h22, 8'h00},
    {2'd1, 8'h33, 8'h00}, {2'd0, 8'h8F, 8'h00}, {2'd1, 8'hA5, 8'h00},
    {2'd1, 8'hB6, 8'h00}, {2'd0, 8'h70, 8'h00}, {2'd2, 8'h00, 8'h11},
    {2'd2, 8'h00, 8'h22}, {2'd2, 8'h00, 8'h33}, {2'd0, 8'h6F, 8'h00},
    {2'd2, 8'h00, 8'hB6}, {2'd2, 8'h00, 8'hB6}, {2'd0, 8'h9F, 8'h00},
    {2'd1, 8'hC7, 8'h00}, {2'd1, 8'hD8, 8'h00}, {2'd0, 8'h70, 8'h00},
    {2'd2, 8'h00, 8'hD8}, {2'd0, 8'h6F, 8'h00}, {2'd2, 8'h00, 8'hC7},
    {2'd0, 8'hA8, 8'h00}, {2'd0, 8'h82, 8'h00}, {2'd1, 8'hFF, 8'h00},
    {2'd0, 8'hA4, 8'h00}, {2'd1, 8'h00, 8'h00}, {2'd0, 8'hA0, 8'h00},
    {2'd0, 8'h62, 8'h00}, {2'd2, 8'h00, 8'h0F}, {2'd0, 8'hB0, 8'h00},
    {2'd0, 8'hD0, 8'h00}, {2'd0, 8'hE0, 8'h00}, {2'd0, 8'h3F, 8'h00},
    {2'd0, 8'h5F, 8'h00}, {2'd2, 8'h00, 8'h0F}, {2'd1, 8'h44, 8'h00},
    {2'd2, 8'h00, 8'h44}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [7:0] b);
    @(negedge clk); cmdValid = 1'b1; cmdByte = b;
    @(negedge clk); cmdValid = 1'b0;
  endtask

  task automatic sendData(input logic [7:0] d);
    @(negedge clk); wrValid = 1'b1; wrData = d;
    @(negedge clk); wrValid = 1'b0;
  endtask

  task automatic readCheck(input logic [7:0] exp, input string req);
    @(negedge clk); rdReq = 1'b1;
    @(negedge clk); rdReq = 1'b0;
    check(rdValid === 1'b1, "R3 rdValid", int'(rdValid), 1);
    check(rdData === exp, req, int'(rdData), int'(exp));
  endtask

  task automatic tick();
    @(negedge clk); scanTick = 1'b1;
    @(negedge clk); scanTick = 1'b0;
  endtask

  task automatic tickTo(input logic [3:0] t);
    for (int n = 0; n < 20 && scanPos != t; n++) tick();
    check(scanPos === t, "R8 scan reach", int'(scanPos), int'(t));
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 40 && busy; n++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rdData === 8'h00, "R1 rdData", int'(rdData), 0);
    check(rdValid === 1'b0, "R1 rdValid", int'(rdValid), 0);
    check(busy === 1'b0, "R1 busy", int'(busy), 0);
    check(scanPos === 4'd0, "R1 scanPos", int'(scanPos), 0);
    check(segOut === 8'h00, "R1 segOut", int'(segOut), 0);

    // R2 R3 R4 R11 vector walk
    for (int v = 0; v < NV; v++) begin
      case (VEC[v][17:16])
        2'd0: sendCmd(VEC[v][15:8]);
        2'd1: sendData(VEC[v][15:8]);
        default: readCheck(VEC[v][7:0], "R2/R3/R4/R11 vector");
      endcase
    end

    // R10 data write in the same cycle as a command is dropped
    @(negedge clk);
    cmdValid = 1'b1; cmdByte = 8'h83; wrValid = 1'b1; wrData = 8'h99;
    @(negedge clk);
    cmdValid = 1'b0; wrValid = 1'b0;
    sendCmd(8'h63);
    readCheck(8'h00, "R10 dropped write");
    sendData(8'h55);
    readCheck(8'h55, "R10 pointer loaded");

    // R5 blanking of each nibble, memory unaffected
    tickTo(4'd0);
    check(segOut === 8'hD8, "R5 unblanked", int'(segOut), 'hD8);
    sendCmd(8'hA2);
    check(segOut === 8'h08, "R5 blank upper", int'(segOut), 'h08);
    sendCmd(8'hA1);
    check(segOut === 8'hD0, "R5 blank lower", int'(segOut), 'hD0);
    sendCmd(8'hA3);
    check(segOut === 8'h00, "R5 blank both", int'(segOut), 0);
    sendCmd(8'hA0);
    sendCmd(8'h60);
    readCheck(8'hD8, "R5 memory kept");

    // R8 scan wrap at 8 and 16 digits
    tickTo(4'd7);
    tick();
    check(scanPos === 4'd0, "R8 wrap at 8", int'(scanPos), 0);
    sendCmd(8'h10);
    tickTo(4'd15);
    check(segOut === 8'hC7, "R8 position 15", int'(segOut), 'hC7);
    tick();
    check(scanPos === 4'd0, "R8 wrap at 16", int'(scanPos), 0);

    // R9 right entry, 8 digits then 16 digits
    sendCmd(8'h08);
    sendData(8'hE1);
    sendData(8'hE2);
    sendCmd(8'h76);
    readCheck(8'hE1, "R9 pos6");
    readCheck(8'hE2, "R9 pos7");
    readCheck(8'h00, "R9 pos8 untouched");
    sendCmd(8'h60);
    readCheck(8'h44, "R9 pos0 shifted");
    sendCmd(8'h6F);
    readCheck(8'hC7, "R9 pos15 untouched");
    sendCmd(8'h18);
    sendData(8'hF0);
    sendCmd(8'h6E);
    readCheck(8'hC7, "R9 wide pos14");
    sendCmd(8'h6F);
    readCheck(8'hF0, "R9 wide pos15");
    sendCmd(8'h60);
    readCheck(8'h55, "R9 wide pos0");

    // R6 R7 clear with traffic injected while busy
    sendCmd(8'h00);
    sendCmd(8'hC8);
    begin
      int cnt = 0;
      while (busy && cnt < 40) begin
        cnt++;
        if (cnt == 2) begin cmdValid = 1'b1; cmdByte = 8'h85; end
        else cmdValid = 1'b0;
        if (cnt == 3) begin wrValid = 1'b1; wrData = 8'h77; end
        else wrValid = 1'b0;
        @(negedge clk);
      end
      cmdValid = 1'b0; wrValid = 1'b0;
      check(cnt == 16, "R6 busy length", cnt, 16);
    end
    sendData(8'h12);
    sendCmd(8'h70);
    readCheck(8'h12, "R7 pointer reset by clear");
    readCheck(8'h20, "R6 fill 0x20");
    sendCmd(8'h65);
    readCheck(8'h20, "R7 write ignored while busy");
    sendCmd(8'h6F);
    readCheck(8'h20, "R6 fill last location");
    sendCmd(8'hCC);
    waitIdle();
    sendCmd(8'h63);
    readCheck(8'hFF, "R6 fill 0xFF");
    sendCmd(8'hC4);
    waitIdle();
    sendCmd(8'h63);
    readCheck(8'h00, "R6 fill 0x00");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule